// File: doc/BRIEF.md
# Flash Self-Timed Operation and Power-Mode Sequencer

This block is the internal sequencer of a serial flash device. Once the command decoder has accepted a write-class operation (status register write, page program, sector erase, block erase or chip erase), the sequencer holds it pending until chip select is released. It then runs a self-timed busy interval whose length is set per operation by a parameter counted in clock ticks. While the interval runs, the busy output feeds the write-in-progress flag. When the interval ends, a one-clock completion pulse lets the status logic clear its write-enable latch.

The same block manages the power modes. After reset it holds off all commands for a start-up delay. A power-down request takes effect a fixed delay after chip select is released. While powered down, only a release request is honoured. The return to standby after a release takes its own delay. The array itself is not modelled: programming and erasing are pure time delays.

Top module: `fseq_top`

## Requirements
- R1: While `rst` is high and after it falls, `pwr_mode` reads 3 (start-up) and `cmd_gate` reads 0. The block leaves start-up at the T_VSL-th rising clock edge that sees `rst` low. From that edge on, `pwr_mode` reads 0 (standby) and `cmd_gate` reads 1.
- R2: A request on `op_req` bits 0 to 4 is taken only while `cmd_gate` is 1. The bits are: 0 status write, 1 page program, 2 sector erase, 3 block erase, 4 chip erase. Once a request is taken, `busy` stays 0 until a `cs_rise` pulse. `busy` rises on the clock edge that samples `cs_rise`.
- R3: `busy` stays high for exactly T_WRSR, T_PP, T_SE, T_BE or T_CE cycles, matching the request bit 0, 1, 2, 3 or 4 that was taken.
- R4: `done` is high for exactly one cycle: the first cycle after a write-class busy interval in which `busy` is 0. At no other time is `done` high.
- R5: When several of bits 0 to 5 are set in the same cycle, the lowest set bit is taken and the others are dropped.
- R6: Requests and `cs_rise` pulses that arrive after an operation is taken, whether it is still pending or already busy, are ignored. The running interval keeps its original length.
- R7: `cmd_gate` is 0 whenever an operation is pending or busy, during start-up, and in every power-down state.
- R8: A request on bit 5 (power-down) followed by `cs_rise` makes `pwr_mode` read 1 (entering) for exactly T_DP cycles, and then 2 (powered down).
- R9: While `pwr_mode` is 2, requests on bits 0 to 5 together with `cs_rise` leave `busy` at 0, `pwr_mode` at 2 and `cmd_gate` at 0.
- R10: While powered down, a request on bit 6 (release) followed by `cs_rise` keeps `pwr_mode` at 2 for exactly T_RES cycles. After that, `pwr_mode` reads 0 and `cmd_gate` reads 1.
- R11: A release request in standby changes nothing. A release request during a busy interval does not change that interval's length.
- R12: A `cs_rise` pulse with no operation pending leaves `busy` at 0 and `cmd_gate` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_req | input | 7 | One pulse per accepted operation; bit meanings given in R2, R8, R10 |
| cs_rise | input | 1 | One-cycle pulse when chip select is released |
| busy | output | 1 | Self-timed interval in progress (write-in-progress flag) |
| done | output | 1 | One-cycle completion pulse after a write-class interval |
| pwr_mode | output | 2 | 0 standby, 1 entering power-down, 2 powered down, 3 start-up |
| cmd_gate | output | 1 | High when a new command may be accepted |

## Verification
Each interval is loaded on the clock edge that samples `cs_rise`, so `busy` or the new `pwr_mode` is already visible one half-cycle later. It then holds for exactly its parameter count of cycles. `done` appears on the first cycle with `busy` low and is gone one cycle later. The bench drives and samples only on falling edges, and measures each interval by counting falling edges on which the output keeps its value. It compares that count against the parameter for the operation it chose. The start-up exit shows up T_VSL-1 falling edges after the first edge with reset low.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    localparam int NUM_OPS  = 7;
    localparam int NUM_ARB  = 6;

    typedef enum logic [2:0] {
        OP_WRSR = 3'd0,
        OP_PP   = 3'd1,
        OP_SE   = 3'd2,
        OP_BE   = 3'd3,
        OP_CE   = 3'd4,
        OP_DPD  = 3'd5,
        OP_REL  = 3'd6
    } op_e;

    typedef enum logic [2:0] {
        S_BOOT   = 3'd0,
        S_IDLE   = 3'd1,
        S_ARMED  = 3'd2,
        S_BUSY   = 3'd3,
        S_DPENT  = 3'd4,
        S_DOWN   = 3'd5,
        S_DPEXIT = 3'd6
    } seq_state_e;

    typedef enum logic [1:0] {
        PM_STBY  = 2'd0,
        PM_ENTER = 2'd1,
        PM_DOWN  = 2'd2,
        PM_BOOT  = 2'd3
    } pmode_e;

    typedef struct packed {
        seq_state_e st;
        op_e        pend;
    } seq_ctx_t;

    function automatic logic is_write(op_e op);
        return op <= OP_CE;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fseq_timer.sv
module fseq_timer #(
    parameter int CW = 8,
    parameter logic [CW-1:0] RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expire
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= RST_VAL;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expire = (cnt == '0);
endmodule

// File: rtl/fseq_arbiter.sv
module fseq_arbiter
    import fseq_pkg::*;
#(
    parameter int N = NUM_ARB
) (
    input  logic [N-1:0] req,
    output logic         pick_valid,
    output op_e          pick_op
);
    logic [N-1:0] seen;
    logic [N-1:0] gnt;

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_chain
            if (gi == 0) begin : g_first
                assign seen[gi] = req[gi];
                assign gnt[gi]  = req[gi];
            end else begin : g_rest
                assign seen[gi] = seen[gi-1] | req[gi];
                assign gnt[gi]  = req[gi] & ~seen[gi-1];
            end
        end
    endgenerate

    always_comb begin
        pick_op = OP_WRSR;
        for (int i = 0; i < N; i++) begin
            if (gnt[i]) pick_op = op_e'(3'(i));
        end
    end

    assign pick_valid = seen[N-1];
endmodule

// File: rtl/fseq_fsm.sv
module fseq_fsm
    import fseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               rel_req,
    input  logic               cs_rise,
    input  logic               pick_valid,
    input  op_e                pick_op,
    input  logic               expire,
    output logic               ld,
    output op_e                ld_kind,
    output seq_state_e         state,
    output logic               done
);
    seq_ctx_t ctx, ctx_nx;
    logic     done_nx;

    always_comb begin
        ctx_nx  = ctx;
        ld      = 1'b0;
        ld_kind = ctx.pend;
        done_nx = 1'b0;
        unique case (ctx.st)
            S_BOOT: begin
                if (expire) ctx_nx.st = S_IDLE;
            end
            S_IDLE: begin
                if (pick_valid) begin
                    ctx_nx.st   = S_ARMED;
                    ctx_nx.pend = pick_op;
                end
            end
            S_ARMED: begin
                if (cs_rise) begin
                    ld = 1'b1;
                    if (is_write(ctx.pend))
                        ctx_nx.st = S_BUSY;
                    else if (ctx.pend == OP_DPD)
                        ctx_nx.st = S_DPENT;
                    else
                        ctx_nx.st = S_DPEXIT;
                end
            end
            S_BUSY: begin
                if (expire) begin
                    ctx_nx.st = S_IDLE;
                    done_nx   = 1'b1;
                end
            end
            S_DPENT: begin
                if (expire) ctx_nx.st = S_DOWN;
            end
            S_DOWN: begin
                if (rel_req) begin
                    ctx_nx.st   = S_ARMED;
                    ctx_nx.pend = OP_REL;
                end
            end
            S_DPEXIT: begin
                if (expire) ctx_nx.st = S_IDLE;
            end
            default: ctx_nx.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx.st   <= S_BOOT;
            ctx.pend <= OP_WRSR;
            done     <= 1'b0;
        end else begin
            ctx  <= ctx_nx;
            done <= done_nx;
        end
    end

    assign state = ctx.st;
endmodule

// File: rtl/fseq_top.sv
module fseq_top
    import fseq_pkg::*;
#(
    parameter int T_WRSR = 5000,
    parameter int T_PP   = 150,
    parameter int T_SE   = 40000,
    parameter int T_BE   = 1000000,
    parameter int T_CE   = 1000000,
    parameter int T_DP   = 20,
    parameter int T_RES  = 20,
    parameter int T_VSL  = 300
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_OPS-1:0]  op_req,
    input  logic                cs_rise,
    output logic                busy,
    output logic                done,
    output logic [1:0]          pwr_mode,
    output logic                cmd_gate
);
    localparam int TMAX = max2(max2(max2(T_WRSR, T_PP), max2(T_SE, T_BE)),
                               max2(max2(T_CE, T_DP), max2(T_RES, T_VSL)));
    localparam int CW = $clog2(TMAX + 1);
    localparam logic [CW-1:0] BOOT_LD = CW'(T_VSL - 1);

    logic          pick_valid;
    op_e           pick_op;
    logic          ld;
    op_e           ld_kind;
    logic [CW-1:0] ld_val;
    logic          expire;
    seq_state_e    state;
    pmode_e        pm;

    fseq_arbiter #(.N(NUM_ARB)) u_arb (
        .req        (op_req[NUM_ARB-1:0]),
        .pick_valid (pick_valid),
        .pick_op    (pick_op)
    );

    fseq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .rel_req    (op_req[OP_REL]),
        .cs_rise    (cs_rise),
        .pick_valid (pick_valid),
        .pick_op    (pick_op),
        .expire     (expire),
        .ld         (ld),
        .ld_kind    (ld_kind),
        .state      (state),
        .done       (done)
    );

    always_comb begin
        unique case (ld_kind)
            OP_WRSR: ld_val = CW'(T_WRSR - 1);
            OP_PP:   ld_val = CW'(T_PP - 1);
            OP_SE:   ld_val = CW'(T_SE - 1);
            OP_BE:   ld_val = CW'(T_BE - 1);
            OP_CE:   ld_val = CW'(T_CE - 1);
            OP_DPD:  ld_val = CW'(T_DP - 1);
            default: ld_val = CW'(T_RES - 1);
        endcase
    end

    fseq_timer #(.CW(CW), .RST_VAL(BOOT_LD)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (ld),
        .load_val (ld_val),
        .expire   (expire)
    );

    always_comb begin
        unique case (state)
            S_BOOT:   pm = PM_BOOT;
            S_DPENT:  pm = PM_ENTER;
            S_DOWN,
            S_DPEXIT: pm = PM_DOWN;
            S_ARMED:  pm = (ld_kind == OP_REL) ? PM_DOWN : PM_STBY;
            default:  pm = PM_STBY;
        endcase
    end

    assign pwr_mode = pm;
    assign busy     = (state == S_BUSY);
    assign cmd_gate = (state == S_IDLE);
endmodule

// File: rtl/fseq_chk.sv
module fseq_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs_rise,
    input logic       busy,
    input logic       done,
    input logic [1:0] pwr_mode,
    input logic       cmd_gate
);
    // R4
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy));

    // R4
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R2
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cs_rise));

    // R7
    gate_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_gate |-> (!busy && pwr_mode == 2'd0));

    // R9
    down_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_mode == 2'd2) |-> (!busy && !cmd_gate));

    // R8
    enter_seq_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_mode == 2'd2 && $past(pwr_mode) != 2'd2) |-> ($past(pwr_mode) == 2'd1));

    // R1
    boot_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_mode != 2'd3 && $past(pwr_mode) == 2'd3) |-> cmd_gate);
endmodule

bind fseq_top fseq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_rise  (cs_rise),
    .busy     (busy),
    .done     (done),
    .pwr_mode (pwr_mode),
    .cmd_gate (cmd_gate)
);

// File: tb/tb_fseq_top.sv
module tb_fseq_top;
    localparam int P_WRSR = 6;
    localparam int P_PP   = 3;
    localparam int P_SE   = 9;
    localparam int P_BE   = 12;
    localparam int P_CE   = 15;
    localparam int P_DP   = 4;
    localparam int P_RES  = 5;
    localparam int P_VSL  = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] op_req = '0;
    logic       cs_rise = 1'b0;
    logic       busy, done, cmd_gate;
    logic [1:0] pwr_mode;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    fseq_top #(
        .T_WRSR(P_WRSR), .T_PP(P_PP), .T_SE(P_SE), .T_BE(P_BE),
        .T_CE(P_CE), .T_DP(P_DP), .T_RES(P_RES), .T_VSL(P_VSL)
    ) dut (
        .clk(clk), .rst(rst), .op_req(op_req), .cs_rise(cs_rise),
        .busy(busy), .done(done), .pwr_mode(pwr_mode), .cmd_gate(cmd_gate)
    );

    function automatic int dur_of(int bitpos);
        case (bitpos)
            0: return P_WRSR;
            1: return P_PP;
            2: return P_SE;
            3: return P_BE;
            default: return P_CE;
        endcase
    endfunction

    function automatic int lowest(int m);
        for (int i = 0; i < 7; i++) if (m[i]) return i;
        return -1;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic measure(input int inj_at, input logic [6:0] inj_mask, output int len);
        len = 0;
        while (busy === 1'b1 && len < 1000) begin
            if (len == inj_at) begin op_req = inj_mask; cs_rise = 1'b1; end
            else begin op_req = '0; cs_rise = 1'b0; end
            len++;
            @(negedge clk);
        end
        op_req = '0; cs_rise = 1'b0;
    endtask

    task automatic run_write(input string req, input logic [6:0] mask, input int exp_len,
                             input int inj_at, input logic [6:0] inj_mask);
        int len;
        op_req = mask;
        @(negedge clk);
        op_req = '0;
        chk({req, " armed gate"}, cmd_gate, 0);
        chk({req, " armed busy"}, busy, 0);
        cs_rise = 1'b1;
        @(negedge clk);
        cs_rise = 1'b0;
        measure(inj_at, inj_mask, len);
        chk({req, " busy length"}, len, exp_len);
        chk({req, " done pulse"}, done, 1);
        @(negedge clk);
        chk({req, " done cleared"}, done, 0);
        chk({req, " gate back"}, cmd_gate, 1);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset mode", pwr_mode, 3);
        chk("R1 reset gate", cmd_gate, 0);
        chk("R1 reset busy", busy, 0);
        rst = 1'b0;
        n = 0;
        @(negedge clk);
        while (pwr_mode == 2'd3 && n < 1000) begin
            if (cmd_gate !== 1'b0) chk("R1 gate in boot", cmd_gate, 0);
            n++;
            @(negedge clk);
        end
        chk("R1 boot length", n, P_VSL - 1);
        chk("R1 standby mode", pwr_mode, 0);
        chk("R1 gate open", cmd_gate, 1);

        // R12 lone cs_rise
        cs_rise = 1'b1;
        @(negedge clk);
        cs_rise = 1'b0;
        chk("R12 busy", busy, 0);
        chk("R12 gate", cmd_gate, 1);

        // R2 R3 R4 each operation
        for (int b = 0; b < 5; b++) run_write("R3", 7'(1 << b), dur_of(b), -1, '0);

        // R5 priority sweep over bits 0..5
        for (int m = 1; m < 64; m++) begin
            if (m != 32) run_write("R5", 7'(m), dur_of(lowest(m)), -1, '0);
        end

        // R6 request while pending
        op_req = 7'b0000100;
        @(negedge clk);
        op_req = 7'b0000010;
        @(negedge clk);
        op_req = '0;
        cs_rise = 1'b1;
        @(negedge clk);
        cs_rise = 1'b0;
        measure(-1, '0, n);
        chk("R6 pending ignore length", n, P_SE);
        @(negedge clk);

        // R6 request while busy
        run_write("R6 busy inject", 7'b0000100, P_SE, 3, 7'b0000001);
        run_write("R6 busy inject late", 7'b0001000, P_BE, P_BE - 1, 7'b0000010);

        // R11 release during busy and in standby
        run_write("R11 release in busy", 7'b0010000, P_CE, 2, 7'b1000000);
        op_req = 7'b1000000;
        cs_rise = 1'b1;
        @(negedge clk);
        op_req = '0; cs_rise = 1'b0;
        chk("R11 standby release mode", pwr_mode, 0);
        chk("R11 standby release gate", cmd_gate, 1);
        @(negedge clk);
        chk("R11 standby release busy", busy, 0);
        chk("R11 standby release gate2", cmd_gate, 1);

        // R8 power-down entry
        op_req = 7'b0100000;
        @(negedge clk);
        op_req = '0;
        chk("R7 pending dp gate", cmd_gate, 0);
        chk("R8 pending dp mode", pwr_mode, 0);
        cs_rise = 1'b1;
        @(negedge clk);
        cs_rise = 1'b0;
        n = 0;
        while (pwr_mode == 2'd1 && n < 1000) begin n++; @(negedge clk); end
        chk("R8 enter length", n, P_DP);
        chk("R8 down mode", pwr_mode, 2);
        chk("R7 down gate", cmd_gate, 0);

        // R9 blocked in power-down
        for (int m = 1; m < 64; m += 9) begin
            op_req = 7'(m);
            @(negedge clk);
            op_req = '0;
            cs_rise = 1'b1;
            @(negedge clk);
            cs_rise = 1'b0;
            repeat (2) @(negedge clk);
            chk("R9 busy", busy, 0);
            chk("R9 mode", pwr_mode, 2);
            chk("R9 gate", cmd_gate, 0);
        end

        // R10 release from power-down
        op_req = 7'b1000000;
        @(negedge clk);
        op_req = '0;
        chk("R10 pending mode", pwr_mode, 2);
        cs_rise = 1'b1;
        @(negedge clk);
        cs_rise = 1'b0;
        n = 0;
        while (pwr_mode == 2'd2 && n < 1000) begin n++; @(negedge clk); end
        chk("R10 exit length", n, P_RES);
        chk("R10 standby mode", pwr_mode, 0);
        chk("R10 gate", cmd_gate, 1);

        run_write("R2 after release", 7'b0000010, P_PP, -1, '0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule